// File: doc/BRIEF.md
# Programmable DRAM Refresh Timer

This block paces refresh for an SDRAM controller. A two-bit rate code picks one of three refresh intervals or turns refresh off. A second two-bit code gives the bus clock frequency, because the memory runs on the same clock as the processor bus. From the two codes the block works out how many clock cycles make up one interval. At the end of each interval it raises a refresh request. The request stays high until the controller acknowledges it.

The controller may still be busy when the next interval ends. In that case no second request is queued. Instead a four-bit saturating counter records the lost refresh, so firmware or a monitor can see that refresh fell behind. Any change to either code restarts the interval at once, so a new setting never inherits a partly elapsed period. Issuing the refresh command and precharging the banks are the controller's job.

The parameter `TIME_DIV` divides every interval by a constant. Its default of 1 gives real-time intervals. A larger value makes intervals short enough for fast simulation.

Top module: `dram_refresh_timer`

## Requirements
- R1: With rate code 00 the interval counter holds its value and no new refresh request is raised. A request already pending stays pending until acknowledged, and the missed count does not change.
- R2: Rate code 01 gives an interval of N = floor(78 * F / (10 * TIME_DIV)) cycles, where F is the frequency in MHz selected by R5. This corresponds to 7.8 us.
- R3: Rate code 10 gives N = floor(156 * F / (10 * TIME_DIV)) cycles, corresponding to 15.6 us.
- R4: Rate code 11 gives N = floor(1250 * F / (10 * TIME_DIV)) cycles, corresponding to 125 us. For every enabled code, N is never below 2.
- R5: Frequency code 00 means F = 66, code 01 means F = 100, and code 10 means F = 133. Code 11 is treated as 133.
- R6: At the end of an interval `refresh_req` goes high on the following clock edge. It stays high until a cycle with `refresh_ack` high clears it on the next edge. If an acknowledge arrives in the same cycle as an interval end, the request stays high and no miss is counted.
- R7: If an interval ends while the request is still pending and no acknowledge is present, `missed_count` rises by one. It saturates at 15, never decreases, and only reset clears it.
- R8: A change of either code is seen at the next clock edge, and that edge reloads the interval counter. The first request under the new setting appears N cycles after that reloading edge.
- R9: After reset `refresh_req` and `missed_count` are 0 and the stored rate is 00. If a nonzero rate is present when reset is released, the first request comes N cycles after the first edge out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory/bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| refresh_rate | input | 2 | Interval code: 00 off, 01 short, 10 medium, 11 long |
| bus_freq_sel | input | 2 | Clock frequency code: 00 66 MHz, 01 100 MHz, 10/11 133 MHz |
| refresh_ack | input | 1 | One-cycle acknowledge from the controller |
| refresh_req | output | 1 | Refresh request, held until acknowledged |
| missed_count | output | 4 | Saturating count of intervals lost while a request was pending |

## Verification
Inputs are driven on the falling edge, so a code change first takes effect at the rising edge E0 that follows. The request is therefore first visible at the falling edge N+1 periods later, and the bench counts falling edges from the change and expects exactly N+1. An acknowledge clears the request one edge after it is sampled, and a miss appears in the count one edge after the interval end. The bench checks both at the falling edge immediately after the edge concerned. For the case where an acknowledge and an interval end coincide, the bench counts exactly N-1 falling edges from the last request before raising the acknowledge.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef enum logic [1:0] {
    RATE_OFF   = 2'b00,
    RATE_SHORT = 2'b01,
    RATE_MID   = 2'b10,
    RATE_LONG  = 2'b11
  } rate_e;

  // Bus clock frequency in MHz for a frequency code (code 11 aliases 133).
  function automatic int unsigned freq_mhz(input logic [1:0] sel);
    case (sel)
      2'b00:   return 66;
      2'b01:   return 100;
      default: return 133;
    endcase
  endfunction

  // Interval length in tenths of a microsecond; 0 when refresh is off.
  function automatic int unsigned period_tenths(input logic [1:0] rate);
    case (rate_e'(rate))
      RATE_SHORT: return 78;
      RATE_MID:   return 156;
      RATE_LONG:  return 1250;
      default:    return 0;
    endcase
  endfunction

  // Cycles per interval; 1 for the off code (value unused), floor of 2 otherwise.
  function automatic int unsigned interval_cycles(input logic [1:0] rate,
                                                  input logic [1:0] sel,
                                                  input int unsigned div);
    int unsigned c;
    if (rate == 2'b00) return 1;
    c = (period_tenths(rate) * freq_mhz(sel)) / (10 * div);
    if (c < 2) c = 2;
    return c;
  endfunction

  function automatic int unsigned longest_interval(input int unsigned div);
    return interval_cycles(2'b11, 2'b10, div);
  endfunction

endpackage

// File: rtl/rt_cfg_track.sv
module rt_cfg_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_in,
  input  logic [1:0] freq_in,
  output logic [1:0] rate_q,
  output logic [1:0] freq_q,
  output logic       cfg_changed
);

  assign cfg_changed = (rate_in != rate_q) || (freq_in != freq_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= 2'b00;
      freq_q <= 2'b00;
    end else begin
      rate_q <= rate_in;
      freq_q <= freq_in;
    end
  end

  AST_CHANGE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_changed |=> (rate_q == $past(rate_in)) && (freq_q == $past(freq_in))) else $error("cfg"); // R8

endmodule

// File: rtl/rt_interval_counter.sv
module rt_interval_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             reload,
  input  logic [CNT_W-1:0] term_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;

  assign expire = enable && !reload && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (reload) begin
      cnt <= term_val;
    end else if (enable) begin
      if (cnt == '0) cnt <= term_val;
      else           cnt <= cnt - 1'b1;
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !reload) |=> $stable(cnt)) else $error("hold"); // R1
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !reload && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)) else $error("down"); // R2
  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !reload) |-> (cnt <= term_val)) else $error("bound"); // R8

endmodule

// File: rtl/rt_req_track.sv
module rt_req_track #(
  parameter int MISS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              ack,
  output logic              req,
  output logic [MISS_W-1:0] miss_count
);

  localparam logic [MISS_W-1:0] MISS_MAX = {MISS_W{1'b1}};

  logic lost_refresh;
  assign lost_refresh = expire && req && !ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req        <= 1'b0;
      miss_count <= '0;
    end else begin
      if (expire)   req <= 1'b1;
      else if (ack) req <= 1'b0;
      if (lost_refresh && miss_count != MISS_MAX)
        miss_count <= miss_count + 1'b1;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req) else $error("hold"); // R6
  AST_MISS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count == MISS_MAX) |=> (miss_count == MISS_MAX)) else $error("sat"); // R7
  AST_MISS_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (miss_count >= $past(miss_count))) else $error("mono"); // R7

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int TIME_DIV = 1,
  parameter int MISS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        refresh_rate,
  input  logic [1:0]        bus_freq_sel,
  input  logic              refresh_ack,
  output logic              refresh_req,
  output logic [MISS_W-1:0] missed_count
);

  localparam int unsigned MAX_CYC = rt_pkg::longest_interval(TIME_DIV);
  localparam int          CNT_W   = $clog2(MAX_CYC + 1);

  logic [1:0]       rate_q;
  logic [1:0]       freq_q;
  logic             cfg_changed;
  logic             interval_end;
  logic             counting;
  logic [CNT_W-1:0] term_val;

  assign counting = (rate_q != 2'b00);
  assign term_val = CNT_W'(rt_pkg::interval_cycles(refresh_rate, bus_freq_sel, TIME_DIV) - 1);

  rt_cfg_track u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .rate_in     (refresh_rate),
    .freq_in     (bus_freq_sel),
    .rate_q      (rate_q),
    .freq_q      (freq_q),
    .cfg_changed (cfg_changed)
  );

  rt_interval_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (counting),
    .reload   (cfg_changed),
    .term_val (term_val),
    .expire   (interval_end)
  );

  rt_req_track #(.MISS_W(MISS_W)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire     (interval_end),
    .ack        (refresh_ack),
    .req        (refresh_req),
    .miss_count (missed_count)
  );

  AST_EXPIRE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    interval_end |=> refresh_req) else $error("raise"); // R6
  AST_OFF_NO_NEW_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!refresh_req && rate_q == 2'b00 && !cfg_changed) |=> !refresh_req) else $error("off"); // R1
  AST_OFF_MISS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == 2'b00 && !cfg_changed) |=> $stable(missed_count)) else $error("offmiss"); // R1

endmodule

// File: tb/tb_dram_refresh_timer.sv
module tb_dram_refresh_timer;

  localparam int DIV = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] refresh_rate = 2'b00;
  logic [1:0] bus_freq_sel = 2'b00;
  logic       refresh_ack = 1'b0;
  logic       refresh_req;
  logic [3:0] missed_count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dram_refresh_timer #(.TIME_DIV(DIV), .MISS_W(4)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .refresh_rate (refresh_rate),
    .bus_freq_sel (bus_freq_sel),
    .refresh_ack  (refresh_ack),
    .refresh_req  (refresh_req),
    .missed_count (missed_count)
  );

  // Expected interval in cycles: nanoseconds times MHz over 1000, then divided.
  function automatic int exp_cycles(input int r, input int s);
    int ns, mhz, n;
    ns  = (r == 1) ? 7800 : (r == 2) ? 15600 : 125000;
    mhz = (s == 0) ? 66 : (s == 1) ? 100 : 133;
    n   = (ns * mhz) / (1000 * DIV);
    return (n < 2) ? 2 : n;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ack_pulse();
    refresh_ack = 1'b1;
    @(negedge clk);
    refresh_ack = 1'b0;
  endtask

  // Apply a setting at a falling edge and count falling edges until the request.
  task automatic measure(input int r, input int s, output int k);
    refresh_rate = 2'(r);
    bus_freq_sel = 2'(s);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!refresh_req && k < 3000);
  endtask

  task automatic go_idle();
    refresh_rate = 2'b00;
    @(negedge clk);
    ack_pulse();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      finish_run();
    end
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    check("R9 reset req", int'(refresh_req), 0);
    check("R9 reset miss", int'(missed_count), 0);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    check("R9 idle after reset", int'(refresh_req), 0);

    // Sweep of every rate and frequency code: R2 R3 R4 R5 R8
    for (int r = 1; r < 4; r++) begin
      for (int s = 0; s < 4; s++) begin
        go_idle();
        measure(r, s, k);
        check($sformatf("R%0d/R5 rate %0d freq %0d", r + 1, r, s), k, exp_cycles(r, s) + 1);
        if (s == 3) check("R5 code 11 as 133", k, exp_cycles(r, 2) + 1);
        ack_pulse();
        check("R6 ack clears", int'(refresh_req), 0);
      end
    end
    check("R7 no misses in sweep", int'(missed_count), 0);

    // R8: mid-interval change restarts the interval
    go_idle();
    measure(1, 1, k);
    ack_pulse();
    repeat (20) @(negedge clk);
    measure(2, 1, k);
    check("R8 reload on change", k, exp_cycles(2, 1) + 1);
    ack_pulse();

    // R6 / R7: misses, coincident ack, saturation
    go_idle();
    measure(1, 0, k);
    check("R2 miss setup", k, exp_cycles(1, 0) + 1);
    repeat (exp_cycles(1, 0)) @(negedge clk);
    check("R7 first miss", int'(missed_count), 1);
    check("R6 req held", int'(refresh_req), 1);
    repeat (exp_cycles(1, 0) - 1) @(negedge clk);
    ack_pulse();
    check("R6 coincident ack keeps req", int'(refresh_req), 1);
    check("R6 coincident ack no miss", int'(missed_count), 1);
    repeat (exp_cycles(1, 0)) @(negedge clk);
    check("R7 second miss", int'(missed_count), 2);
    repeat (16 * exp_cycles(1, 0)) @(negedge clk);
    check("R7 saturates", int'(missed_count), 15);
    repeat (2 * exp_cycles(1, 0)) @(negedge clk);
    check("R7 stays saturated", int'(missed_count), 15);
    ack_pulse();
    check("R7 ack leaves count", int'(missed_count), 15);

    // R1: rate off produces nothing
    go_idle();
    repeat (2000) @(negedge clk);
    check("R1 off no request", int'(refresh_req), 0);
    check("R1 off miss unchanged", int'(missed_count), 15);

    // R9: reset with a nonzero rate present
    refresh_rate = 2'b01;
    bus_freq_sel = 2'b00;
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears miss", int'(missed_count), 0);
    check("R9 reset clears req", int'(refresh_req), 0);
    rst_n = 1'b1;
    measure(1, 0, k);
    check("R9 first request after reset", k, exp_cycles(1, 0) + 1);

    finish_run();
  end

endmodule